// File: doc/BRIEF.md
# Touchscreen Conversion Mask Controller

This block decides when a touchscreen conversion may start sampling. A conversion request is held pending until a noise-mask input and a pen-down comparator input both allow it. The block then raises a one-cycle sample strobe for the converter. It also drives a screen-drive enable that powers the resistive plates around the sample, and a busy flag that covers the time a request is pending.

The mask input lets the system keep sampling away from known noise sources such as display inversion pulses. A two-bit mode selects how the mask is used:

- Ignore it.
- Block sampling while it is high.
- Treat each mask edge as the start of a programmable quiet window.
- Wait for a mask edge and start the screen drive there, with the sample taken a programmable delay later.

Pen-down qualification stops screen drive and sampling while the pen is lifted. A force bit overrides it so that non-screen channels can still be converted. The comparator level is also brought out on a pin whose polarity is selectable.

Top module: `tsc_mask_gate`

## Requirements
- R1: While reset is high and in the cycle after it, `sample_stb`, `scr_drive` and `busy` are low. `pen_det` follows the synchronized comparator level, which resets to 0.
- R2: Mode 2'b00 ignores `mask_in`. A request sampled at a clock edge makes `busy` high after that edge. If the pen is accepted, `sample_stb` rises at the next edge and `busy` falls at that same edge.
- R3: In mode 2'b01, a pending request does not strobe while the synchronized mask is high. A low mask does not delay the strobe. The strobe follows the third edge after the mask falls.
- R4: In mode 2'b10, every change of the synchronized mask starts a quiet window, whether or not a request is pending. A pending request strobes at the first edge after the window ends. With code N and the tick held high, the strobe is N+5 edges after the raw mask toggle. When no window is open, a request strobes as in R2.
- R5: In mode 2'b10, a mask change during an open window restarts the window from the full code.
- R6: In mode 2'b11, a pending request waits for a mask change. `scr_drive` rises at the third edge after the raw toggle. The strobe follows N+5 edges after the toggle, so code 0 gives a strobe 5 edges after the toggle.
- R7: `sample_stb` is high for exactly one cycle. `scr_drive` is high in the strobe cycle and in the cycle after it, and low in the cycle after that.
- R8: With `pen_force` low, no strobe is issued and `scr_drive` stays low while the synchronized comparator is low. The comparator reads high when the pen is down.
- R9: With `pen_force` high, a pending request strobes at the next edge regardless of the comparator.
- R10: `pen_det` equals the synchronized comparator level when `pen_pol` is 0, and its inverse when `pen_pol` is 1. A comparator change appears on `pen_det` two edges later.
- R11: A request that arrives while `busy` is high, or in the strobe cycle, is ignored. No second strobe follows.
- R12: Any change of `mask_mode` aborts a pending cycle. `busy` is low after the next edge, and no strobe follows.
- R13: The quiet window counts only cycles in which `tick_en` is high. With the tick held low, no strobe occurs. After the tick goes high with N=2 remaining, the strobe follows 4 edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Time-base enable that advances the delay count |
| conv_req | input | 1 | Conversion request, accepted only when idle |
| mask_in | input | 1 | Raw noise-mask input (asynchronous) |
| pen_cmp_in | input | 1 | Raw pen comparator output, high means pen down (asynchronous) |
| mask_mode | input | 2 | Mask mode: 00 ignore, 01 level block, 10 edge window, 11 edge launch |
| dly_code | input | DW | Delay code in ticks |
| pen_force | input | 1 | Overrides pen-down qualification |
| pen_pol | input | 1 | Inverts `pen_det` when set |
| scr_drive | output | 1 | Screen-drive enable |
| sample_stb | output | 1 | One-cycle sample strobe |
| busy | output | 1 | A request is pending |
| pen_det | output | 1 | Polarity-adjusted pen-detect level |

## Verification
Some properties are checked by the assertions on every cycle:

- The strobe is a single pulse and is followed by one cycle of drive.
- Busy is low whenever the strobe is high, and it rises only after a request.
- No strobe is issued while the level mask blocks or, without the force bit, while the pen is up.
- A mode change leaves the block idle.
- Drive in edge-launch mode starts only on a mask change.
- The delay counter holds while the tick is low.

The bench scenarios are needed for the exact timing behaviours. These are the edge counts from a mask toggle to drive and to strobe in both edge modes, the restart of the quiet window on a second edge, the resumption of counting once the tick returns, the polarity of the pen pin, and the dropping of a request made during the strobe cycle.

// File: rtl/tsc_mask_pkg.sv
package tsc_mask_pkg;

    typedef enum logic [1:0] {
        MSK_OFF    = 2'b00,
        MSK_LEVEL  = 2'b01,
        MSK_RETRIG = 2'b10,
        MSK_SYNC   = 2'b11
    } msk_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PEND,
        ST_LAUNCH,
        ST_TAIL
    } seq_state_e;

    typedef struct packed {
        logic mask;
        logic pen;
    } pin_pair_t;

    // Start condition for a pending request in the modes without edge launch
    function automatic logic free_launch_ok(msk_mode_e m, logic pen_ok,
                                            logic mask_lvl, logic hold,
                                            logic edge_seen);
        logic gate;
        case (m)
            MSK_OFF:    gate = 1'b1;
            MSK_LEVEL:  gate = !mask_lvl;
            MSK_RETRIG: gate = !hold && !edge_seen;
            default:    gate = 1'b0;
        endcase
        return pen_ok && gate;
    endfunction

endpackage

// File: rtl/tsc_pin_sync.sv
module tsc_pin_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/tsc_dly_timer.sv
module tsc_dly_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          clear,
    input  logic          tick,
    input  logic [CW-1:0] code,
    output logic          active
);
    logic [CW-1:0] cnt;
    logic          act;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            act <= 1'b0;
            cnt <= '0;
        end else if (load) begin
            act <= 1'b1;
            cnt <= code;
        end else if (act) begin
            if (cnt == '0)   act <= 1'b0;
            else if (tick)   cnt <= cnt - 1'b1;
        end
    end

    assign active = act;

    // R13: without a tick a running window neither advances nor closes
    a_r13_tick_hold: assert property (@(posedge clk) disable iff (rst)
        (act && !tick && !load && !clear && cnt != '0) |=> (act && $stable(cnt)));
endmodule

// File: rtl/tsc_mask_gate.sv
module tsc_mask_gate
    import tsc_mask_pkg::*;
#(
    parameter int DW     = 4,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_en,
    input  logic          conv_req,
    input  logic          mask_in,
    input  logic          pen_cmp_in,
    input  logic [1:0]    mask_mode,
    input  logic [DW-1:0] dly_code,
    input  logic          pen_force,
    input  logic          pen_pol,
    output logic          scr_drive,
    output logic          sample_stb,
    output logic          busy,
    output logic          pen_det
);
    localparam int PINS = $bits(pin_pair_t);

    pin_pair_t  raw, lvl;
    msk_mode_e  mode;
    seq_state_e st;
    logic [1:0] mode_q;
    logic       mask_q, mask_edge, mode_chg, pen_ok;
    logic       hold, tmr_load, tmr_clear;
    logic       stb_q, drv_q;

    assign raw.mask = mask_in;
    assign raw.pen  = pen_cmp_in;

    tsc_pin_sync #(.W(PINS), .STAGES(STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (raw),
        .dout(lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) mask_q <= 1'b0;
        else     mask_q <= lvl.mask;
    end

    assign mode      = msk_mode_e'(mask_mode);
    assign mask_edge = lvl.mask ^ mask_q;
    assign mode_chg  = (mask_mode != mode_q);
    assign pen_ok    = pen_force | lvl.pen;

    assign tmr_load  = !mode_chg &&
                       ((mode == MSK_RETRIG && mask_edge) ||
                        (mode == MSK_SYNC && st == ST_PEND && mask_edge && pen_ok));
    assign tmr_clear = mode_chg || (st == ST_LAUNCH && !pen_ok);

    tsc_dly_timer #(.CW(DW)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .load  (tmr_load),
        .clear (tmr_clear),
        .tick  (tick_en),
        .code  (dly_code),
        .active(hold)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            stb_q  <= 1'b0;
            drv_q  <= 1'b0;
            mode_q <= mask_mode;
        end else begin
            mode_q <= mask_mode;
            stb_q  <= 1'b0;
            if (mode_chg) begin
                st    <= ST_IDLE;
                drv_q <= 1'b0;
            end else begin
                case (st)
                    ST_IDLE: begin
                        drv_q <= 1'b0;
                        if (conv_req) st <= ST_PEND;
                    end
                    ST_PEND: begin
                        if (mode == MSK_SYNC) begin
                            drv_q <= 1'b0;
                            if (mask_edge && pen_ok) begin
                                st    <= ST_LAUNCH;
                                drv_q <= 1'b1;
                            end
                        end else begin
                            drv_q <= pen_ok;
                            if (free_launch_ok(mode, pen_ok, lvl.mask, hold, mask_edge)) begin
                                st    <= ST_TAIL;
                                stb_q <= 1'b1;
                            end
                        end
                    end
                    ST_LAUNCH: begin
                        if (!pen_ok) begin
                            st    <= ST_PEND;
                            drv_q <= 1'b0;
                        end else if (!hold) begin
                            st    <= ST_TAIL;
                            stb_q <= 1'b1;
                        end
                    end
                    default: begin
                        drv_q <= 1'b1;
                        st    <= ST_IDLE;
                    end
                endcase
            end
        end
    end

    assign sample_stb = stb_q;
    assign scr_drive  = drv_q;
    assign busy       = (st == ST_PEND) || (st == ST_LAUNCH);
    assign pen_det    = lvl.pen ^ pen_pol;

    a_r7_stb_single: assert property (@(posedge clk) disable iff (rst)
        sample_stb |=> !sample_stb);
    a_r7_drive_tail: assert property (@(posedge clk) disable iff (rst)
        sample_stb |=> scr_drive);
    a_r2_busy_drop: assert property (@(posedge clk) disable iff (rst)
        sample_stb |-> !busy);
    a_r11_busy_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(conv_req));
    a_r3_level_block: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PEND && mode == MSK_LEVEL && lvl.mask && !mode_chg) |=> !sample_stb);
    a_r8_pen_gate: assert property (@(posedge clk) disable iff (rst)
        (sample_stb && !$past(pen_force)) |-> $past(lvl.pen));
    a_r12_abort: assert property (@(posedge clk) disable iff (rst)
        (mask_mode != $past(mask_mode)) |=> (!busy && !sample_stb));
    a_r6_sync_launch: assert property (@(posedge clk) disable iff (rst)
        (mode == MSK_SYNC && !mode_chg && $rose(scr_drive)) |-> $past(mask_edge));
endmodule

// File: tb/test_tsc_mask_gate.sv
module test_tsc_mask_gate;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b1;
    logic       conv_req = 1'b0;
    logic       mask_in = 1'b0;
    logic       pen_cmp_in = 1'b0;
    logic [1:0] mask_mode = 2'b00;
    logic [3:0] dly_code = 4'd0;
    logic       pen_force = 1'b0;
    logic       pen_pol = 1'b0;
    logic       scr_drive, sample_stb, busy, pen_det;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    tsc_mask_gate i_tsc_mask_gate (
        .clk(clk), .rst(rst), .tick_en(tick_en), .conv_req(conv_req),
        .mask_in(mask_in), .pen_cmp_in(pen_cmp_in), .mask_mode(mask_mode),
        .dly_code(dly_code), .pen_force(pen_force), .pen_pol(pen_pol),
        .scr_drive(scr_drive), .sample_stb(sample_stb), .busy(busy),
        .pen_det(pen_det)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setup(input logic [1:0] m, input logic [3:0] code);
        @(negedge clk);
        mask_mode = m;
        dly_code  = code;
        tick_en   = 1'b1;
        pen_force = 1'b0;
        pen_cmp_in = 1'b1;
        conv_req  = 1'b0;
        settle(24);
    endtask

    task automatic t_reset();
        settle(4);
        chk("R1 stb in reset", int'(sample_stb), 0);
        chk("R1 drive in reset", int'(scr_drive), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 stb after reset", int'(sample_stb), 0);
        chk("R1 pen_det after reset", int'(pen_det), 0);
    endtask

    task automatic t_mode_off();
        setup(2'b00, 4'd0);
        conv_req = 1'b1;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            if (k == 1) begin
                chk("R2 busy after request", int'(busy), 1);
                chk("R2 no early stb", int'(sample_stb), 0);
                conv_req = 1'b0;
            end
            if (k == 2) begin
                chk("R2 stb", int'(sample_stb), 1);
                chk("R2 busy falls with stb", int'(busy), 0);
                chk("R7 drive in stb cycle", int'(scr_drive), 1);
                conv_req = 1'b1;   // R11: request during strobe cycle
            end
            if (k == 3) begin
                chk("R7 stb single", int'(sample_stb), 0);
                chk("R7 drive tail", int'(scr_drive), 1);
                chk("R11 request in strobe cycle ignored", int'(busy), 0);
                conv_req = 1'b0;
            end
            if (k == 4) begin
                chk("R7 drive off", int'(scr_drive), 0);
                chk("R11 still idle", int'(busy), 0);
            end
        end
    endtask

    task automatic t_pen();
        int seen = 0;
        setup(2'b00, 4'd0);
        pen_cmp_in = 1'b0;
        settle(4);
        conv_req = 1'b1;
        @(negedge clk);
        conv_req = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (sample_stb || scr_drive) seen++;
        end
        chk("R8 no stb or drive with pen up", seen, 0);
        chk("R8 still pending", int'(busy), 1);
        pen_force = 1'b1;
        @(negedge clk);
        chk("R9 force strobes next edge", int'(sample_stb), 1);
        settle(4);
        conv_req = 1'b1;
        @(negedge clk);
        conv_req = 1'b0;
        @(negedge clk);
        chk("R9 forced request strobes", int'(sample_stb), 1);
        pen_force = 1'b0;
    endtask

    task automatic t_level();
        int seen = 0;
        setup(2'b01, 4'd0);
        conv_req = 1'b1;
        @(negedge clk);
        conv_req = 1'b0;
        @(negedge clk);
        chk("R3 low mask no delay", int'(sample_stb), 1);
        mask_in = 1'b1;
        settle(6);
        conv_req = 1'b1;
        @(negedge clk);
        conv_req = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (sample_stb) seen++;
        end
        chk("R3 blocked while mask high", seen, 0);
        mask_in = 1'b0;
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            if (k < 3) chk("R3 not before third edge", int'(sample_stb), 0);
            else       chk("R3 strobe after mask falls", int'(sample_stb), 1);
        end
    endtask

    task automatic t_retrig(input bit second);
        int hit = -1;
        setup(2'b10, 4'd3);
        conv_req = 1'b1;
        @(negedge clk);
        conv_req = 1'b0;
        @(negedge clk);
        chk("R4 free run without edge", int'(sample_stb), 1);
        settle(4);
        mask_in = ~mask_in;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (k == 3) conv_req = 1'b1;
            if (k == 4) begin
                conv_req = 1'b0;
                chk("R4 request pending in window", int'(busy), 1);
                if (second) mask_in = ~mask_in;
            end
            if (sample_stb && hit < 0) hit = k;
        end
        if (second) chk("R5 restarted window strobe edge", hit, 12);
        else        chk("R4 window strobe edge", hit, 8);
    endtask

    task automatic t_sync(input logic [3:0] code);
        int hit = -1;
        int seen = 0;
        setup(2'b11, code);
        conv_req = 1'b1;
        @(negedge clk);
        conv_req = 1'b0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (sample_stb || scr_drive) seen++;
        end
        chk("R6 waits for edge", seen, 0);
        mask_in = ~mask_in;
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            if (k == 2) chk("R6 drive not yet", int'(scr_drive), 0);
            if (k == 3) begin
                chk("R6 drive at launch", int'(scr_drive), 1);
                conv_req = 1'b1;   // R11: request while busy
            end
            if (k == 4) conv_req = 1'b0;
            if (sample_stb && hit < 0) hit = k;
            if (hit > 0 && k == hit + 2) chk("R7 drive off after tail", int'(scr_drive), 0);
        end
        chk("R6 strobe edge", hit, int'(code) + 5);
        seen = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (sample_stb || busy) seen++;
        end
        chk("R11 request while busy ignored", seen, 0);
    endtask

    task automatic t_tick();
        int seen = 0;
        setup(2'b11, 4'd2);
        tick_en = 1'b0;
        conv_req = 1'b1;
        @(negedge clk);
        conv_req = 1'b0;
        mask_in = ~mask_in;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (sample_stb) seen++;
        end
        chk("R13 no strobe without tick", seen, 0);
        chk("R13 drive held", int'(scr_drive), 1);
        tick_en = 1'b1;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            if (k == 4) chk("R13 strobe after ticks", int'(sample_stb), 1);
            else        chk("R13 no early strobe", int'(sample_stb), 0);
        end
    endtask

    task automatic t_abort();
        int seen = 0;
        setup(2'b11, 4'd0);
        conv_req = 1'b1;
        @(negedge clk);
        conv_req = 1'b0;
        settle(3);
        chk("R12 pending before change", int'(busy), 1);
        mask_mode = 2'b00;
        @(negedge clk);
        chk("R12 busy cleared", int'(busy), 0);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (sample_stb) seen++;
        end
        chk("R12 no strobe after abort", seen, 0);
    endtask

    task automatic t_pol();
        setup(2'b00, 4'd0);
        chk("R10 active high", int'(pen_det), 1);
        pen_pol = 1'b1;
        #1;
        chk("R10 inverted", int'(pen_det), 0);
        @(negedge clk);
        pen_cmp_in = 1'b0;
        @(negedge clk);
        chk("R10 sync latency 1", int'(pen_det), 0);
        @(negedge clk);
        chk("R10 sync latency 2", int'(pen_det), 1);
        pen_pol = 1'b0;
    endtask

    initial begin
        t_reset();
        t_mode_off();
        t_pen();
        t_level();
        t_retrig(1'b0);
        t_retrig(1'b1);
        t_sync(4'd0);
        t_sync(4'd2);
        t_tick();
        t_abort();
        t_pol();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule